// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block sits between a CPU and an on-chip Flash array. Software drives it through four byte-wide I/O registers: a column select, a row select, a data port and a command/status register. A byte written to the data port is programmed into the array at the selected row and column. The command register starts three operations: an erase of the whole array, an erase of one page, or a burst program of one row. In a row burst, a hardware incrementer moves the column along after each byte. Each operation is timed by a cycle counter that is derived from a clock-frequency parameter. When an operation ends, the block clears its own command bit.

The CPU memory port reads the Flash directly. While an erase runs, any memory read or write that targets Flash is stalled with `mem_wait`. While a row burst runs, only Flash reads are stalled. Accesses to addresses above the Flash region are never stalled. The cell array is a behavioural model: an erased byte reads 0xFF, and programming can only clear bits, so the stored value becomes the old byte ANDed with the new one.

The sequencer has four states. In `ST_IDLE` no operation runs. `ST_MASS_ERASE`, `ST_PAGE_ERASE` and `ST_ROW_PROG` each mark one running operation. The named transitions are:
- start-mass: IDLE→MASS_ERASE.
- start-page: IDLE→PAGE_ERASE.
- start-row: IDLE→ROW_PROG.
- erase-done: MASS_ERASE or PAGE_ERASE→IDLE, when the timer expires.
- row-wrap: ROW_PROG→IDLE, when the byte at column 127 has been written.
- row-timeout: ROW_PROG→IDLE, when the timer expires with no byte written.

Top module: `flash_prog_seq`

## Requirements
- R1: After reset, the column, row and command registers read 0. The column register (io_addr 0) holds 7 bits, and its bit 7 always reads 0.
- R2: In IDLE, a write to the data port (io_addr 2) programs the byte at linear address row*128+column. The row select is at io_addr 1. The stored value becomes old AND new, and the column register does not change.
- R3: In ROW_PROG, each data-port write programs the byte at the current column and then advances the column by one. The advanced column can be read back while the burst runs.
- R4: When a burst byte is written at column 127, ROW_PROG ends. The column reads 0, the command register's row bit (bit 2) clears, and the timeout flag (bit 5) stays 0.
- R5: If TOUT_CYC cycles pass in ROW_PROG with no byte written, the burst ends and bit 5 is set. Bit 5 stays set through writes that hold 0 in bit 5, and a write of 1 to bit 5 clears it.
- R6: A write with bit 1 set starts a page erase of the page that holds the selected row. The erase lasts exactly PAGE_CYC cycles. Bits 1 and 7 read 1 while it runs. Afterwards the page reads 0xFF, and other pages keep their contents.
- R7: A write with bit 0 set starts a mass erase lasting exactly MASS_CYC cycles. Afterwards every main byte and every information-page byte reads 0xFF.
- R8: During an erase, a memory access to a Flash address holds mem_wait for every remaining cycle of the erase. An access to a non-Flash address (address ≥ 2304) sees mem_wait at 0.
- R9: During ROW_PROG, Flash reads hold mem_wait until the burst ends, while Flash memory writes see mem_wait at 0.
- R10: While any operation runs, bit 7 reads 1. Command-bit writes are ignored: no further operation follows. Writes to the column and row registers are also ignored.
- R11: When one write sets several command bits, mass erase wins over page erase, and page erase wins over row program.
- R12: A Flash read is accepted on the first clock edge where mem_valid is high and mem_wait is low, and its data is on mem_rdata after that edge. An I/O read returns its data after the edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_valid | input | 1 | CPU memory access request |
| mem_write | input | 1 | 1 = write, 0 = read (Flash memory writes are not stored) |
| mem_addr | input | ADDR_W | CPU byte address; below 2304 is Flash |
| mem_rdata | output | 8 | Flash read data |
| mem_wait | output | 1 | Stall for the current memory access |
| io_valid | input | 1 | I/O register access |
| io_write | input | 1 | 1 = write, 0 = read |
| io_addr | input | 2 | 0 column, 1 row, 2 data, 3 command/status |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data |

## Verification
An erase started by a command write on edge E0 holds mem_wait from the cycle after E0 through edge E0+N. A Flash read issued in the very next cycle therefore counts exactly N wait cycles: PAGE_CYC or MASS_CYC. Every I/O access the bench inserts first shortens that count by one cycle. For a row burst, a read issued just after the last byte write counts exactly TOUT_CYC waits. Register and Flash data are due one edge after acceptance. The bench drives 1 ns after a rising edge, takes wait samples at falling edges, and takes data 1 ns after the accepting edge, so each result is read in the cycle it is due.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PAGE_ERASE,
        ST_MASS_ERASE,
        ST_ROW_PROG
    } seq_state_t;

    localparam logic [1:0] REG_COL  = 2'd0;
    localparam logic [1:0] REG_ROW  = 2'd1;
    localparam logic [1:0] REG_DATA = 2'd2;
    localparam logic [1:0] REG_CTRL = 2'd3;

    localparam int CB_MASS = 0;
    localparam int CB_PAGE = 1;
    localparam int CB_ROW  = 2;
    localparam int CB_TOUT = 5;
    localparam int CB_BUSY = 7;

endpackage

// File: rtl/flash_cell_array.sv
module flash_cell_array #(
    parameter int DEPTH = 2304,
    parameter int AW    = 12
) (
    input  logic          clk,
    input  logic          prog_en,
    input  logic [AW-1:0] prog_addr,
    input  logic [7:0]    prog_data,
    input  logic          erase_en,
    input  logic [AW:0]   erase_lo,
    input  logic [AW:0]   erase_hi,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);

    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (erase_en && i >= int'(erase_lo) && i < int'(erase_hi))
                cells[i] <= 8'hFF;
        end
        if (prog_en && int'(prog_addr) < DEPTH)
            cells[prog_addr] <= cells[prog_addr] & prog_data;
        if (rd_en && int'(rd_addr) < DEPTH)
            rd_data <= cells[rd_addr];
    end

endmodule

// File: rtl/flash_op_timer.sv
module flash_op_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         run,
    output logic         done
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (run && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = run && !load && (cnt == '0);

    // R6, R7, R5: the window shrinks by exactly one per running cycle
    a_r6_timer_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
    import flash_seq_pkg::*;
#(
    parameter int TMR_W    = 8,
    parameter int PAGE_CYC = 10,
    parameter int MASS_CYC = 20,
    parameter int TOUT_CYC = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_mass,
    input  logic             go_page,
    input  logic             go_row,
    input  logic             byte_wr,
    input  logic             col_last,
    input  logic             tmr_done,
    output seq_state_t       state,
    output logic             tmr_load,
    output logic [TMR_W-1:0] tmr_val,
    output logic             erase_go,
    output logic             erase_all,
    output logic             row_timeout
);

    seq_state_t nxt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (go_mass)      nxt = ST_MASS_ERASE;
                else if (go_page) nxt = ST_PAGE_ERASE;
                else if (go_row)  nxt = ST_ROW_PROG;
            end
            ST_PAGE_ERASE,
            ST_MASS_ERASE: begin
                if (tmr_done) nxt = ST_IDLE;
            end
            ST_ROW_PROG: begin
                if (byte_wr && col_last)      nxt = ST_IDLE;
                else if (!byte_wr && tmr_done) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        tmr_load    = 1'b0;
        tmr_val     = '0;
        erase_go    = 1'b0;
        erase_all   = 1'b0;
        row_timeout = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (go_mass) begin
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(MASS_CYC - 1);
                end else if (go_page) begin
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(PAGE_CYC - 1);
                end else if (go_row) begin
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(TOUT_CYC - 1);
                end
            end
            ST_PAGE_ERASE: erase_go = tmr_done;
            ST_MASS_ERASE: begin
                erase_go  = tmr_done;
                erase_all = tmr_done;
            end
            ST_ROW_PROG: begin
                if (byte_wr && !col_last) begin
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(TOUT_CYC - 1);
                end else if (!byte_wr && tmr_done) begin
                    row_timeout = 1'b1;
                end
            end
            default: ;
        endcase
    end

    // R6: an erase leaves its state on the cycle after expiry
    a_r6_erase_returns: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_PAGE_ERASE || state == ST_MASS_ERASE) && tmr_done) |=> (state == ST_IDLE));

    // R11: mass erase wins whenever it is requested
    a_r11_mass_first: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && go_mass) |=> (state == ST_MASS_ERASE));

    // R10: a running operation never turns into another one
    a_r10_no_switch: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> (state == $past(state) || state == ST_IDLE));

endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
    import flash_seq_pkg::*;
#(
    parameter int CLK_HZ         = 20_000_000,
    parameter int PAGE_ERASE_US  = 10_000,
    parameter int MASS_ERASE_US  = 200_000,
    parameter int ROW_TIMEOUT_US = 50,
    parameter int ROW_BYTES      = 128,
    parameter int PAGE_BYTES     = 1024,
    parameter int PAGES          = 2,
    parameter int INFO_BYTES     = 256,
    parameter int ADDR_W         = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mem_valid,
    input  logic              mem_write,
    input  logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_rdata,
    output logic              mem_wait,
    input  logic              io_valid,
    input  logic              io_write,
    input  logic [1:0]        io_addr,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata
);

    localparam int COL_W         = $clog2(ROW_BYTES);
    localparam int ROWS_PER_PAGE = PAGE_BYTES / ROW_BYTES;
    localparam int MAIN_BYTES    = PAGES * PAGE_BYTES;
    localparam int TOTAL_BYTES   = MAIN_BYTES + INFO_BYTES;
    localparam int TOTAL_ROWS    = TOTAL_BYTES / ROW_BYTES;
    localparam int MAIN_ROWS     = MAIN_BYTES / ROW_BYTES;
    localparam int ROW_W         = $clog2(TOTAL_ROWS);
    localparam int LIN_W         = ROW_W + COL_W;
    localparam int CYC_PER_US    = CLK_HZ / 1_000_000;
    localparam int PAGE_CYC      = CYC_PER_US * PAGE_ERASE_US;
    localparam int MASS_CYC      = CYC_PER_US * MASS_ERASE_US;
    localparam int TOUT_CYC      = CYC_PER_US * ROW_TIMEOUT_US;
    localparam int MAX_A         = (PAGE_CYC > TOUT_CYC) ? PAGE_CYC : TOUT_CYC;
    localparam int MAX_CYC       = (MASS_CYC > MAX_A) ? MASS_CYC : MAX_A;
    localparam int TMR_W         = $clog2(MAX_CYC + 1);
    localparam logic [COL_W-1:0] COL_END = COL_W'(ROW_BYTES - 1);

    seq_state_t         state;
    logic [COL_W-1:0]   col_q;
    logic [ROW_W-1:0]   row_q;
    logic               tflag_q;
    logic               busy, in_flash;
    logic               wr_col, wr_row, wr_data, wr_ctrl, byte_wr;
    logic               go_mass, go_page, go_row;
    logic               tmr_load, tmr_done, erase_go, erase_all, row_timeout;
    logic [TMR_W-1:0]   tmr_val;
    logic [LIN_W:0]     erase_lo, erase_hi;
    logic               rd_en;
    logic [7:0]         ctrl_view;

    assign busy     = (state != ST_IDLE);
    assign in_flash = (mem_addr < ADDR_W'(TOTAL_BYTES));

    assign wr_col  = io_valid && io_write && io_addr == REG_COL;
    assign wr_row  = io_valid && io_write && io_addr == REG_ROW;
    assign wr_data = io_valid && io_write && io_addr == REG_DATA;
    assign wr_ctrl = io_valid && io_write && io_addr == REG_CTRL;
    assign byte_wr = wr_data && (state == ST_IDLE || state == ST_ROW_PROG);

    assign go_mass = wr_ctrl && !busy && io_wdata[CB_MASS];
    assign go_page = wr_ctrl && !busy && io_wdata[CB_PAGE];
    assign go_row  = wr_ctrl && !busy && io_wdata[CB_ROW];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q <= '0;
            row_q <= '0;
        end else begin
            if (!busy && wr_col)
                col_q <= io_wdata[COL_W-1:0];
            else if (state == ST_ROW_PROG && byte_wr)
                col_q <= col_q + 1'b1;
            if (!busy && wr_row)
                row_q <= io_wdata[ROW_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            tflag_q <= 1'b0;
        else if (row_timeout)
            tflag_q <= 1'b1;
        else if (wr_ctrl && io_wdata[CB_TOUT])
            tflag_q <= 1'b0;
    end

    always_comb begin
        ctrl_view          = '0;
        ctrl_view[CB_MASS] = (state == ST_MASS_ERASE);
        ctrl_view[CB_PAGE] = (state == ST_PAGE_ERASE);
        ctrl_view[CB_ROW]  = (state == ST_ROW_PROG);
        ctrl_view[CB_TOUT] = tflag_q;
        ctrl_view[CB_BUSY] = busy;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            io_rdata <= '0;
        else if (io_valid && !io_write) begin
            unique case (io_addr)
                REG_COL:  io_rdata <= 8'(col_q);
                REG_ROW:  io_rdata <= 8'(row_q);
                REG_DATA: io_rdata <= '0;
                REG_CTRL: io_rdata <= ctrl_view;
                default:  io_rdata <= '0;
            endcase
        end
    end

    always_comb begin
        if (erase_all) begin
            erase_lo = '0;
            erase_hi = (LIN_W+1)'(TOTAL_BYTES);
        end else if (int'(row_q) >= MAIN_ROWS) begin
            erase_lo = (LIN_W+1)'(MAIN_BYTES);
            erase_hi = (LIN_W+1)'(TOTAL_BYTES);
        end else begin
            erase_lo = (LIN_W+1)'((int'(row_q) / ROWS_PER_PAGE) * PAGE_BYTES);
            erase_hi = erase_lo + (LIN_W+1)'(PAGE_BYTES);
        end
    end

    always_comb begin
        mem_wait = 1'b0;
        if (mem_valid && in_flash) begin
            if (state == ST_PAGE_ERASE || state == ST_MASS_ERASE)
                mem_wait = 1'b1;
            else if (state == ST_ROW_PROG && !mem_write)
                mem_wait = 1'b1;
        end
    end

    assign rd_en = mem_valid && !mem_write && in_flash && !mem_wait;

    flash_seq_fsm #(
        .TMR_W    (TMR_W),
        .PAGE_CYC (PAGE_CYC),
        .MASS_CYC (MASS_CYC),
        .TOUT_CYC (TOUT_CYC)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .go_mass     (go_mass),
        .go_page     (go_page),
        .go_row      (go_row),
        .byte_wr     (byte_wr),
        .col_last    (col_q == COL_END),
        .tmr_done    (tmr_done),
        .state       (state),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .erase_go    (erase_go),
        .erase_all   (erase_all),
        .row_timeout (row_timeout)
    );

    flash_op_timer #(.W(TMR_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .run      (busy),
        .done     (tmr_done)
    );

    flash_cell_array #(.DEPTH(TOTAL_BYTES), .AW(LIN_W)) u_cells (
        .clk       (clk),
        .prog_en   (byte_wr),
        .prog_addr ({row_q, col_q}),
        .prog_data (io_wdata),
        .erase_en  (erase_go),
        .erase_lo  (erase_lo),
        .erase_hi  (erase_hi),
        .rd_en     (rd_en),
        .rd_addr   (mem_addr[LIN_W-1:0]),
        .rd_data   (mem_rdata)
    );

    // R1: the column register never shows bit 7
    a_r1_col_msb_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (io_valid && !io_write && io_addr == REG_COL) |=> (io_rdata[7] == 1'b0));

    // R3: a burst byte below the last column advances the column by one
    a_r3_col_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ROW_PROG && byte_wr && col_q != COL_END) |=> (col_q == $past(col_q) + 1'b1));

    // R4: the last-column byte wraps the column and ends the burst
    a_r4_col_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ROW_PROG && byte_wr && col_q == COL_END) |=> (col_q == '0 && state == ST_IDLE));

    // R5: an idle burst window sets the sticky flag
    a_r5_tout_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ROW_PROG && tmr_done && !byte_wr) |=> tflag_q);

    // R10: column and row writes are dropped during an operation
    a_r10_sel_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (wr_col || wr_row)) |=> ($stable(col_q) && $stable(row_q)));

endmodule

// File: tb/sim_flash_prog_seq.sv
`timescale 1ns/100ps
module sim_flash_prog_seq;

    localparam int PAGE_CYC = 30;
    localparam int MASS_CYC = 50;
    localparam int TOUT_CYC = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_valid = 1'b0, mem_write = 1'b0;
    logic [15:0] mem_addr = '0;
    logic [7:0]  mem_rdata;
    logic        mem_wait;
    logic        io_valid = 1'b0, io_write = 1'b0;
    logic [1:0]  io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    flash_prog_seq #(
        .CLK_HZ(1_000_000), .PAGE_ERASE_US(PAGE_CYC),
        .MASS_ERASE_US(MASS_CYC), .ROW_TIMEOUT_US(TOUT_CYC)
    ) u0 (
        .clk(clk), .rst_n(rst_n),
        .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .mem_wait(mem_wait),
        .io_valid(io_valid), .io_write(io_write), .io_addr(io_addr),
        .io_wdata(io_wdata), .io_rdata(io_rdata)
    );

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic io_wr(logic [1:0] a, logic [7:0] d);
        io_valid = 1'b1; io_write = 1'b1; io_addr = a; io_wdata = d;
        @(posedge clk); #1;
        io_valid = 1'b0; io_write = 1'b0;
    endtask

    task automatic io_rd(logic [1:0] a, output logic [7:0] d);
        io_valid = 1'b1; io_write = 1'b0; io_addr = a;
        @(posedge clk); #1;
        io_valid = 1'b0;
        d = io_rdata;
    endtask

    task automatic mem_rd(logic [15:0] a, output logic [7:0] d, output int waits);
        mem_valid = 1'b1; mem_write = 1'b0; mem_addr = a; waits = 0;
        @(negedge clk);
        while (mem_wait) begin
            waits++;
            @(negedge clk);
        end
        @(posedge clk); #1;
        mem_valid = 1'b0;
        d = mem_rdata;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        io_rd(2'd0, d); chk("R1 col after reset", d, 8'h00);
        io_rd(2'd1, d); chk("R1 row after reset", d, 8'h00);
        io_rd(2'd3, d); chk("R1 ctrl after reset", d, 8'h00);
    endtask

    task automatic t_col_reg();
        logic [7:0] d;
        io_wr(2'd0, 8'hFF);
        io_rd(2'd0, d); chk("R1 col bit7 reads 0", d, 8'h7F);
    endtask

    task automatic t_mass();
        logic [7:0] d; int w;
        io_wr(2'd3, 8'h01);
        mem_rd(16'd0, d, w);
        chk("R7 R8 mass erase wait cycles", w, MASS_CYC);
        chk("R7 byte 0 erased", d, 8'hFF);
        mem_rd(16'd2047, d, w); chk("R7 last main byte erased", d, 8'hFF);
        mem_rd(16'd2048, d, w); chk("R7 first info byte erased", d, 8'hFF);
        mem_rd(16'd2303, d, w); chk("R7 last info byte erased", d, 8'hFF);
        chk("R12 idle read no wait", w, 0);
        io_rd(2'd3, d); chk("R7 ctrl clear after mass", d, 8'h00);
    endtask

    task automatic t_single();
        logic [7:0] d; int w;
        io_wr(2'd1, 8'd3);
        io_wr(2'd0, 8'd5);
        io_wr(2'd2, 8'hA5);
        mem_rd(16'd389, d, w); chk("R2 single byte programmed", d, 8'hA5);
        io_rd(2'd0, d); chk("R2 col unchanged", d, 8'h05);
        io_wr(2'd2, 8'h3C);
        mem_rd(16'd389, d, w); chk("R2 program ANDs bits", d, 8'h24);
    endtask

    task automatic t_page();
        logic [7:0] d; int w;
        io_wr(2'd1, 8'd1); io_wr(2'd0, 8'd0); io_wr(2'd2, 8'h11);
        io_wr(2'd1, 8'd9); io_wr(2'd0, 8'd2); io_wr(2'd2, 8'h22);
        io_wr(2'd3, 8'h02);
        io_rd(2'd3, d); chk("R6 R10 ctrl during page erase", d, 8'h82);
        io_wr(2'd0, 8'h40);
        io_wr(2'd3, 8'h01);
        mem_rd(16'd1154, d, w);
        chk("R6 R8 page erase remaining waits", w, PAGE_CYC - 3);
        chk("R6 selected page erased", d, 8'hFF);
        mem_rd(16'd128, d, w); chk("R6 R10 other page kept", d, 8'h11);
        io_rd(2'd0, d); chk("R10 col write ignored while busy", d, 8'h02);
        io_rd(2'd3, d); chk("R10 no queued command", d, 8'h00);
    endtask

    task automatic t_row_full();
        logic [7:0] d; int w;
        io_wr(2'd1, 8'd4); io_wr(2'd0, 8'd124);
        io_wr(2'd3, 8'h04);
        mem_valid = 1'b1; mem_write = 1'b1; mem_addr = 16'd600;
        @(negedge clk); chk("R9 flash write during burst no wait", mem_wait, 0);
        @(posedge clk); #1; mem_valid = 1'b0; mem_write = 1'b0;
        io_wr(2'd2, 8'h10); io_wr(2'd2, 8'h20);
        io_rd(2'd0, d); chk("R3 column advanced", d, 8'd126);
        io_rd(2'd3, d); chk("R3 ctrl during burst", d, 8'h84);
        io_wr(2'd2, 8'h30); io_wr(2'd2, 8'h40);
        io_rd(2'd3, d); chk("R4 burst ended at col 127", d, 8'h00);
        io_rd(2'd0, d); chk("R4 column wrapped", d, 8'h00);
        mem_rd(16'd636, d, w); chk("R3 byte col124", d, 8'h10);
        mem_rd(16'd637, d, w); chk("R3 byte col125", d, 8'h20);
        mem_rd(16'd638, d, w); chk("R3 byte col126", d, 8'h30);
        mem_rd(16'd639, d, w); chk("R3 byte col127", d, 8'h40);
    endtask

    task automatic t_row_timeout();
        logic [7:0] d; int w;
        io_wr(2'd1, 8'd5); io_wr(2'd0, 8'd0);
        io_wr(2'd3, 8'h04);
        io_wr(2'd2, 8'h5A); io_wr(2'd2, 8'h6B);
        mem_rd(16'd640, d, w);
        chk("R9 R5 burst read waits until timeout", w, TOUT_CYC);
        chk("R12 R3 first burst byte", d, 8'h5A);
        io_rd(2'd3, d); chk("R5 timeout flag set", d, 8'h20);
        io_rd(2'd0, d); chk("R5 column after timeout", d, 8'h02);
        io_wr(2'd3, 8'h00);
        io_rd(2'd3, d); chk("R5 flag sticky", d, 8'h20);
        io_wr(2'd3, 8'h20);
        io_rd(2'd3, d); chk("R5 flag cleared by 1", d, 8'h00);
    endtask

    task automatic t_priority();
        logic [7:0] d; int w;
        io_wr(2'd3, 8'h07);
        io_rd(2'd3, d); chk("R11 mass wins", d, 8'h81);
        mem_rd(16'h8000, d, w); chk("R8 non-flash no wait", w, 0);
        mem_rd(16'd389, d, w);
        chk("R11 R8 remaining mass waits", w, MASS_CYC - 2);
        chk("R11 mass erased page 0", d, 8'hFF);
        io_rd(2'd3, d); chk("R11 no follow-on op", d, 8'h00);
    endtask

    initial begin
        repeat (100_000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_col_reg();
        t_mass();
        t_single();
        t_page();
        t_row_full();
        t_row_timeout();
        t_priority();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule